// File: doc/BRIEF.md
# Reset Source and Limp-Home Controller

This block gathers every cause of a system reset into one place. Three causes tied to supply and temperature can produce either a short or a long pulse: a rising undervoltage flag, a power-on event and an exit from overtemperature. The choice between short and long comes from a strap detect input. The watchdog request, the software-reset bit and a refused sleep request always produce the short pulse. The outgoing pulse drives the shared active-low reset pin low. Its length is counted in ticks of a prescaled 1 ms time base.

A low level applied to the pin from outside is filtered. It counts as a reset event only after it has been seen for a minimum number of consecutive cycles, and only while the block is not driving the pin itself. The block also gates a fail-safe enable output.

It keeps a two-stage limp-home state. Every reset sets a warning bit. A reset that arrives while the warning bit is still set latches a control bit, which pulls the active-low limp output low. Overtemperature holds the control bit set. Software clears each bit with its own strobe.

Top module: `rsc_reset_ctrl`

## Requirements
- R1: An external reset (rst_pin_i low while rst_pin_drv_o is 0) becomes a reset event only after FLT_CYCLES consecutive low cycles, and it counts once per low period. A shorter low changes neither lhw_o nor en_o. An external reset never starts an outgoing pulse.
- R2: A rising edge of uv_i, a pon_evt_i strobe or an otp_exit_i strobe sets rst_pin_drv_o from the next cycle. The pulse lasts LONG_TICKS*TICK_DIV cycles when strap_short_i is 0 and SHORT_TICKS*TICK_DIV cycles when strap_short_i is 1. If one of these causes arrives in the same cycle as a short-only cause, the width follows these three causes.
- R3: A wdg_rst_i strobe, a swr_i strobe or a refused sleep request sets rst_pin_drv_o from the next cycle for SHORT_TICKS*TICK_DIV cycles, whatever the value of strap_short_i.
- R4: A sleep request (sleep_req_i, raised when mode code 2'b01 is written) is refused and causes a reset when int_low_i is 1, when wake_pend_i is 1, or when wake_en_i is 3'b000. In every other case it causes nothing.
- R5: A new internal cause that arrives while a pulse is running restarts the pulse. The pulse then ends the full width of the new cause after it.
- R6: en_o is 1 only when en_ctrl_i is 1, mode_i is 2'b10 or 2'b11, no pulse is being driven, and no recognised external reset is still holding the pin low. From the cycle after a reset event, en_o is 0.
- R7: Every reset event sets lhw_o from the next cycle. A lhw_clr_i strobe clears it, unless a reset event occurs in the same cycle, in which case the bit stays set.
- R8: A reset event that occurs while lhw_o is 1 sets lhc_o from the next cycle, and limp_no goes to 0.
- R9: While otp_mode_i is 1, lhc_o is held at 1 and lhc_clr_i has no effect. Once otp_mode_i is 0, a lhc_clr_i strobe clears lhc_o and limp_no returns to 1.
- R10: During reset, rst_pin_drv_o is 0, lhw_o is 0, lhc_o is 0 and limp_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_pin_i | input | 1 | Sensed level of the reset pin, synchronised |
| rst_pin_drv_o | output | 1 | 1 pulls the reset pin low |
| wdg_rst_i | input | 1 | Watchdog reset request strobe |
| uv_i | input | 1 | Supply undervoltage flag |
| pon_evt_i | input | 1 | Power-on (leaving off) strobe |
| otp_exit_i | input | 1 | Leaving overtemperature strobe |
| otp_mode_i | input | 1 | Overtemperature mode active |
| swr_i | input | 1 | Software-reset bit written as 1 |
| sleep_req_i | input | 1 | Sleep mode code written |
| int_low_i | input | 1 | Interrupt pin is low |
| wake_pend_i | input | 1 | Wake-up pending |
| wake_en_i | input | 3 | Wake-source enables |
| strap_short_i | input | 1 | Short-pulse strap detected |
| en_ctrl_i | input | 1 | Enable control bit |
| mode_i | input | 2 | Operating mode code |
| lhw_clr_i | input | 1 | Software clear of the warning bit |
| lhc_clr_i | input | 1 | Software clear of the control bit |
| en_o | output | 1 | Fail-safe enable output |
| limp_no | output | 1 | Active-low limp-home output |
| lhw_o | output | 1 | Limp-home warning bit |
| lhc_o | output | 1 | Limp-home control bit |

## Verification
The bench builds the block with TICK_DIV=4, SHORT_TICKS=2, LONG_TICKS=5 and FLT_CYCLES=3. With these values every pulse ends in 8 or 20 cycles, so the full pulse length can be measured for each cause under both strap settings. Also in reach are all 32 combinations of the sleep-refusal inputs, every external low length from below to above the filter limit, and all eight combinations of enable bit and mode code. The small prescaler also makes a restart inside a running pulse easy to place at an exact tick offset.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic {PW_SHORT = 1'b0, PW_LONG = 1'b1} pulse_w_e;

  function automatic logic sleep_refused(logic int_low, logic wake_pend, logic [2:0] wake_en);
    return int_low | wake_pend | (wake_en == 3'b000);
  endfunction
endpackage

// File: rtl/rsc_pin_filter.sv
module rsc_pin_filter #(
  parameter int FLT_CYCLES = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic mask_i,
  output logic evt_o,
  output logic hold_o
);
  localparam int CW = (FLT_CYCLES > 2) ? $clog2(FLT_CYCLES) : 1;
  localparam logic [CW-1:0] CMAX = CW'(FLT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          hold_q;
  logic          low;

  assign low   = ~pin_i & ~mask_i;
  assign evt_o = low & (cnt_q == CMAX) & ~hold_q;
  assign hold_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      if (!low)               cnt_q <= '0;
      else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
      if (pin_i)              hold_q <= 1'b0;
      else if (evt_o)         hold_q <= 1'b1;
    end
  end

  // R1
  ext_low_seen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(~pin_i & ~mask_i));
  // R1
  ext_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o);
endmodule

// File: rtl/rsc_pulse_gen.sv
module rsc_pulse_gen
  import rsc_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 20
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  pulse_w_e wsel_i,
  output logic     busy_o
);
  localparam int RW = $clog2(LONG_TICKS + 1);
  localparam logic [RW-1:0] W_SHORT = RW'(SHORT_TICKS);
  localparam logic [RW-1:0] W_LONG  = RW'(LONG_TICKS);

  logic [RW-1:0] rem_q;
  logic          tick;

  assign busy_o = (rem_q != '0);

  generate
    if (TICK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(TICK_DIV);
      logic [DW-1:0] div_q;
      assign tick = (div_q == DW'(TICK_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               div_q <= '0;
        else if (load_i || !busy_o) div_q <= '0;
        else if (tick)             div_q <= '0;
        else                       div_q <= div_q + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rem_q <= '0;
    else if (load_i)        rem_q <= (wsel_i == PW_LONG) ? W_LONG : W_SHORT;
    else if (busy_o && tick) rem_q <= rem_q - 1'b1;
  end

  // R2 R3
  pulse_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> busy_o);
  // R5
  pulse_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(load_i));
endmodule

// File: rtl/rsc_limp_ctrl.sv
module rsc_limp_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_i,
  input  logic warn_clr_i,
  input  logic force_i,
  input  logic ctrl_clr_i,
  output logic warn_o,
  output logic ctrl_o
);
  logic warn_q, ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_q <= 1'b0;
      ctrl_q <= 1'b0;
    end else begin
      if (evt_i)           warn_q <= 1'b1;
      else if (warn_clr_i) warn_q <= 1'b0;
      if (force_i || (evt_i && warn_q)) ctrl_q <= 1'b1;
      else if (ctrl_clr_i)               ctrl_q <= 1'b0;
    end
  end

  assign warn_o = warn_q;
  assign ctrl_o = ctrl_q;

  // R7
  warn_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i |=> warn_o);
  // R8
  second_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && warn_o) |=> ctrl_o);
  // R9
  otp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_i |=> ctrl_o);
  // R9
  ctrl_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctrl_o) |-> ($past(ctrl_clr_i) && !$past(force_i)));
endmodule

// File: rtl/rsc_reset_ctrl.sv
module rsc_reset_ctrl
  import rsc_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int FLT_CYCLES  = 200,
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rst_pin_i,
  output logic       rst_pin_drv_o,
  input  logic       wdg_rst_i,
  input  logic       uv_i,
  input  logic       pon_evt_i,
  input  logic       otp_exit_i,
  input  logic       otp_mode_i,
  input  logic       swr_i,
  input  logic       sleep_req_i,
  input  logic       int_low_i,
  input  logic       wake_pend_i,
  input  logic [2:0] wake_en_i,
  input  logic       strap_short_i,
  input  logic       en_ctrl_i,
  input  logic [1:0] mode_i,
  input  logic       lhw_clr_i,
  input  logic       lhc_clr_i,
  output logic       en_o,
  output logic       limp_no,
  output logic       lhw_o,
  output logic       lhc_o
);
  logic     uv_q, uv_rise;
  logic     sleep_fault, long_evt, short_evt, load, sys_evt;
  logic     ext_evt, ext_hold, busy;
  pulse_w_e wsel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) uv_q <= 1'b0;
    else         uv_q <= uv_i;
  end

  assign uv_rise     = uv_i & ~uv_q;
  assign sleep_fault = sleep_req_i & sleep_refused(int_low_i, wake_pend_i, wake_en_i);
  assign long_evt    = uv_rise | pon_evt_i | otp_exit_i;
  assign short_evt   = wdg_rst_i | swr_i | sleep_fault;
  assign load        = long_evt | short_evt;
  assign wsel        = (long_evt && !strap_short_i) ? PW_LONG : PW_SHORT;
  assign sys_evt     = load | ext_evt;

  rsc_pin_filter #(.FLT_CYCLES(FLT_CYCLES)) i_filter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (rst_pin_i),
    .mask_i (busy),
    .evt_o  (ext_evt),
    .hold_o (ext_hold)
  );

  rsc_pulse_gen #(
    .TICK_DIV   (TICK_DIV),
    .SHORT_TICKS(SHORT_TICKS),
    .LONG_TICKS (LONG_TICKS)
  ) i_pulse (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .wsel_i (wsel),
    .busy_o (busy)
  );

  rsc_limp_ctrl i_limp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (sys_evt),
    .warn_clr_i (lhw_clr_i),
    .force_i    (otp_mode_i),
    .ctrl_clr_i (lhc_clr_i),
    .warn_o     (lhw_o),
    .ctrl_o     (lhc_o)
  );

  assign rst_pin_drv_o = busy;
  assign en_o          = en_ctrl_i & mode_i[1] & ~busy & ~ext_hold;
  assign limp_no       = ~lhc_o;

  // R6
  en_after_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_evt |=> !en_o);
  // R4
  sleep_ok_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && !int_low_i && !wake_pend_i && (wake_en_i != 3'b000)
     && !wdg_rst_i && !swr_i && !pon_evt_i && !otp_exit_i && !uv_rise && !rst_pin_drv_o)
    |=> !rst_pin_drv_o);
endmodule

// File: tb/test_rsc_reset_ctrl.sv
module test_rsc_reset_ctrl;
  localparam int DIV = 4, FLT = 3, SW = 2, LW = 5;

  logic clk = 0, rst_n = 0;
  logic drv, ext_low = 0, pin;
  logic wdg = 0, uv = 0, pon = 0, otpx = 0, otpm = 0, swr = 0, slp = 0;
  logic intl = 0, wpend = 0, strap = 0, enc = 0, lhwc = 0, lhcc = 0;
  logic [2:0] wen = 3'b001;
  logic [1:0] mode = 2'b00;
  logic en, limp_n, lhw, lhc;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;
  assign pin = ~(drv | ext_low);

  rsc_reset_ctrl #(.TICK_DIV(DIV), .FLT_CYCLES(FLT), .SHORT_TICKS(SW), .LONG_TICKS(LW)) i_rsc_reset_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .rst_pin_i(pin), .rst_pin_drv_o(drv),
    .wdg_rst_i(wdg), .uv_i(uv), .pon_evt_i(pon), .otp_exit_i(otpx), .otp_mode_i(otpm),
    .swr_i(swr), .sleep_req_i(slp), .int_low_i(intl), .wake_pend_i(wpend), .wake_en_i(wen),
    .strap_short_i(strap), .en_ctrl_i(enc), .mode_i(mode), .lhw_clr_i(lhwc), .lhc_clr_i(lhcc),
    .en_o(en), .limp_no(limp_n), .lhw_o(lhw), .lhc_o(lhc));

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cause(int which, logic v);
    case (which)
      0: uv = v;
      1: pon = v;
      2: otpx = v;
      3: wdg = v;
      4: swr = v;
      default: begin slp = v; wen = v ? 3'b000 : 3'b001; end
    endcase
  endtask

  task automatic fire(int which);
    set_cause(which, 1'b1);
    @(negedge clk);
    set_cause(which, 1'b0);
  endtask

  task automatic measure(output int n);
    n = 0;
    while (drv === 1'b1 && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clr_lhw();
    lhwc = 1; @(negedge clk); lhwc = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R10
    chk(drv == 0 && lhw == 0 && lhc == 0 && limp_n == 1, "R10 reset state",
        {drv, lhw, lhc, limp_n}, 4'b0001);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 width per cause and strap
    for (int s = 0; s < 2; s++) begin
      for (int w = 0; w < 6; w++) begin
        strap = s[0];
        fire(w);
        measure(n);
        if (w < 3) chk(n == ((s == 0) ? LW : SW) * DIV, "R2 pulse width", n, ((s == 0) ? LW : SW) * DIV);
        else       chk(n == SW * DIV, "R3 pulse width", n, SW * DIV);
        @(negedge clk);
      end
    end
    strap = 0;

    // R2 long and short cause together
    wdg = 1; pon = 1; @(negedge clk); wdg = 0; pon = 0;
    measure(n);
    chk(n == LW * DIV, "R2 mixed causes", n, LW * DIV);

    // R5 restart inside a running pulse
    for (int off = 1; off < 8; off += 3) begin
      fire(1);
      repeat (off) @(negedge clk);
      fire(3);
      measure(n);
      chk(n == SW * DIV, "R5 restart width", n, SW * DIV);
    end

    // R4 all sleep-refusal combinations
    for (int c = 0; c < 32; c++) begin
      bit exp;
      clr_lhw();
      intl = c[0]; wpend = c[1]; wen = c[4:2];
      exp = c[0] | c[1] | (c[4:2] == 0);
      slp = 1; @(negedge clk); slp = 0;
      chk(drv == exp, "R4 sleep reset", drv, exp);
      chk(lhw == exp, "R4 sleep warn", lhw, exp);
      measure(n);
    end
    intl = 0; wpend = 0; wen = 3'b001;

    // R1 external low of several lengths
    enc = 1; mode = 2'b10;
    for (int len = 1; len <= 5; len++) begin
      bit exp;
      clr_lhw();
      exp = (len >= FLT);
      ext_low = 1;
      repeat (len) @(negedge clk);
      chk(en == !exp, "R1 en during external low", en, !exp);
      ext_low = 0;
      @(negedge clk);
      chk(lhw == exp, "R1 external recognised", lhw, exp);
      chk(drv == 0, "R1 no outgoing pulse", drv, 0);
    end

    // R6 enable gating
    for (int c = 0; c < 8; c++) begin
      enc = c[2]; mode = c[1:0];
      @(negedge clk);
      chk(en == (c[2] & c[1]), "R6 enable", en, c[2] & c[1]);
    end
    enc = 1; mode = 2'b11;
    fire(4);
    chk(en == 0, "R6 enable low in reset", en, 0);
    measure(n);
    chk(en == 1, "R6 enable back", en, 1);

    // R7 R8 R9 limp-home
    lhcc = 1; @(negedge clk); lhcc = 0;
    clr_lhw();
    chk(lhw == 0 && lhc == 0, "R7 warn cleared", lhw, 0);
    fire(3);
    chk(lhw == 1 && lhc == 0, "R7 first reset warns", {lhw, lhc}, 2'b10);
    measure(n);
    fire(3);
    chk(lhc == 1 && limp_n == 0, "R8 second reset limps", {lhc, limp_n}, 2'b10);
    measure(n);
    lhwc = 1; wdg = 1; @(negedge clk); lhwc = 0; wdg = 0;
    chk(lhw == 1, "R7 set wins over clear", lhw, 1);
    measure(n);
    lhcc = 1; @(negedge clk); lhcc = 0;
    chk(lhc == 0 && limp_n == 1, "R9 clear releases", {lhc, limp_n}, 2'b01);
    otpm = 1; @(negedge clk);
    chk(lhc == 1 && limp_n == 0, "R9 otp forces", {lhc, limp_n}, 2'b10);
    lhcc = 1; @(negedge clk); lhcc = 0;
    chk(lhc == 1, "R9 clear ignored in otp", lhc, 1);
    otpm = 0; @(negedge clk);
    lhcc = 1; @(negedge clk); lhcc = 0;
    chk(lhc == 0 && limp_n == 1, "R9 clear after otp", {lhc, limp_n}, 2'b01);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule